// File: doc/BRIEF.md
# Immediate-Controlled Four-Element Shuffle

This block rearranges vector elements under the control of an 8-bit immediate. The source vector is split into aligned groups of four elements. Each of the four positions in a group has its own 2-bit selector in the immediate, and that selector chooses which element of the same group lands there. The element width can be 8, 16 or 32 bits. A fourth, 64-bit form works differently. For each 128-bit lane, each output doubleword picks either the source vector or the previous destination vector, and then picks one of that lane's two doublewords.

Vectors are 128 or 256 bits long and are processed one 128-bit lane at a time, so data never crosses a lane boundary. In 128-bit mode the upper lane of the result is cleared. Every output is computed from the inputs captured in the same cycle, so the destination register can be both an operand and the target. The result is registered and marked by a one-cycle valid pulse.

Top module: `quad_shuffle`

## Requirements
- R1: While reset is asserted and after its release, `res_valid` is 0 and `res_vec` is all zeros until the first accepted operation.
- R2: An operation presented with `op_valid` high appears on `res_vec` at the next rising clock edge, with `res_valid` high for exactly that one cycle. Cycles without `op_valid` leave `res_vec` unchanged.
- R3: `elem_sel` selects the element width: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits and 3 is the 64-bit form. For widths 8, 16 and 32, output element i takes source element (i rounded down to a multiple of 4) plus the selector for position i mod 4.
- R4: Position p of a group (p = 0..3) is controlled by immediate bits [2p+1:2p]. The immediate 0xE4 reproduces the source unchanged.
- R5: When `len_256` is 1, the upper 128-bit lane is shuffled with the same pattern, using indices relative to the start of that lane. No element moves between lanes.
- R6: In the 64-bit form, the low doubleword of each lane comes from `src_vec` if immediate bit 1 is 1 and from `dst_vec` if it is 0. Immediate bit 0 picks which doubleword of that lane is taken.
- R7: In the 64-bit form, the high doubleword of each lane uses immediate bit 3 as the source select (1 means `src_vec`) and bit 2 as the doubleword select.
- R8: When `len_256` is 0, bits [255:128] of the result are zero, whatever the upper halves of the input vectors hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation present this cycle |
| src_vec | input | 256 | Source vector |
| dst_vec | input | 256 | Previous destination vector, read by the 64-bit form |
| shuf_imm | input | 8 | Four 2-bit position selectors |
| elem_sel | input | 2 | Element width code (0:8, 1:16, 2:32, 3:64-bit form) |
| len_256 | input | 1 | 1 for a 256-bit vector, 0 for a 128-bit vector |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_vec | output | 256 | Registered result |

## Verification
Every one of the 256 immediates is run for each element-width code in both vector lengths, with fresh random data in both input vectors each time. Distinct random elements show whether each position was routed from the right index, and separate fields catch any mix-up of selector fields. In 128-bit mode the upper input halves are also random, so any leak into the cleared upper lane shows up. In the 64-bit form both vectors carry different data, so swapping the source select with the doubleword select is detected. An idle cycle after each result shows whether the output holds steady and the valid pulse lasts only one cycle.

// File: rtl/shuf4_pkg.sv
package shuf4_pkg;
    localparam int VEC_W  = 256;
    localparam int LANE_W = 128;

    typedef enum logic [1:0] {
        EW_BYTE  = 2'd0,
        EW_HALF  = 2'd1,
        EW_WORD  = 2'd2,
        EW_DWORD = 2'd3
    } elem_w_e;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] data;
    } res_state_t;
endpackage

// File: rtl/shuf4_lane_perm.sv
module shuf4_lane_perm
    import shuf4_pkg::*;
#(
    parameter int LANE_BITS = LANE_W
) (
    input  logic [LANE_BITS-1:0] lane_in,
    input  logic [7:0]           imm,
    input  logic [1:0]           width_sel,
    output logic [LANE_BITS-1:0] lane_out
);
    localparam int NUM_W = 3;

    logic [NUM_W-1:0][LANE_BITS-1:0] by_width;

    for (genvar g = 0; g < NUM_W; g++) begin : g_width
        localparam int EW = 8 << g;
        localparam int NE = LANE_BITS / EW;
        for (genvar i = 0; i < NE; i++) begin : g_elem
            localparam int POS  = i % 4;
            localparam int GRP0 = i - POS;
            logic [1:0] fld;
            assign fld = imm[2*POS +: 2];
            assign by_width[g][i*EW +: EW] = lane_in[(GRP0 + int'(fld))*EW +: EW];
        end
    end

    always_comb begin
        case (elem_w_e'(width_sel))
            EW_BYTE: lane_out = by_width[0];
            EW_HALF: lane_out = by_width[1];
            default: lane_out = by_width[2];
        endcase
    end
endmodule

// File: rtl/shuf4_dword_mix.sv
module shuf4_dword_mix
    import shuf4_pkg::*;
#(
    parameter int LANE_BITS = LANE_W
) (
    input  logic [LANE_BITS-1:0] src_lane,
    input  logic [LANE_BITS-1:0] dst_lane,
    input  logic [7:0]           imm,
    output logic [LANE_BITS-1:0] mix_lane
);
    localparam int DW = LANE_BITS / 2;

    logic [DW-1:0] lo_pick, hi_pick;

    function automatic logic [DW-1:0] half_of(input logic [LANE_BITS-1:0] v,
                                              input logic upper);
        return upper ? v[LANE_BITS-1:DW] : v[DW-1:0];
    endfunction

    always_comb begin
        lo_pick  = imm[1] ? half_of(src_lane, imm[0]) : half_of(dst_lane, imm[0]);
        hi_pick  = imm[3] ? half_of(src_lane, imm[2]) : half_of(dst_lane, imm[2]);
        mix_lane = {hi_pick, lo_pick};
    end
endmodule

// File: rtl/quad_shuffle.sv
module quad_shuffle
    import shuf4_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [VEC_W-1:0] src_vec,
    input  logic [VEC_W-1:0] dst_vec,
    input  logic [7:0]       shuf_imm,
    input  logic [1:0]       elem_sel,
    input  logic             len_256,
    output logic             res_valid,
    output logic [VEC_W-1:0] res_vec
);
    localparam int LANES = VEC_W / LANE_W;

    logic [LANES-1:0][LANE_W-1:0] perm_res;
    logic [LANES-1:0][LANE_W-1:0] mix_res;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        shuf4_lane_perm #(.LANE_BITS(LANE_W)) i_perm (
            .lane_in  (src_vec[l*LANE_W +: LANE_W]),
            .imm      (shuf_imm),
            .width_sel(elem_sel),
            .lane_out (perm_res[l])
        );
        shuf4_dword_mix #(.LANE_BITS(LANE_W)) i_mix (
            .src_lane(src_vec[l*LANE_W +: LANE_W]),
            .dst_lane(dst_vec[l*LANE_W +: LANE_W]),
            .imm     (shuf_imm),
            .mix_lane(mix_res[l])
        );
    end

    res_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = op_valid;
        if (op_valid) begin
            for (int l = 0; l < LANES; l++) begin
                if (l == 0 || len_256) begin
                    st_d.data[l*LANE_W +: LANE_W] =
                        (elem_w_e'(elem_sel) == EW_DWORD) ? mix_res[l] : perm_res[l];
                end else begin
                    st_d.data[l*LANE_W +: LANE_W] = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.vld;
    assign res_vec   = st_q.data;

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && $stable(res_vec)));

    // R8
    upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !len_256) |=> (res_vec[VEC_W-1:LANE_W] == '0));

    // R4
    identity_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && elem_sel == 2'd2 && shuf_imm == 8'hE4)
            |=> (res_vec[LANE_W-1:0] == $past(src_vec[LANE_W-1:0])));

    // R6
    low_from_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && elem_sel == 2'd3 && shuf_imm[1:0] == 2'b00)
            |=> (res_vec[63:0] == $past(dst_vec[63:0])));
endmodule

// File: tb/test_quad_shuffle.sv
`timescale 1ns/1ps
module test_quad_shuffle;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         op_valid;
    logic [255:0] src_vec, dst_vec;
    logic [7:0]   shuf_imm;
    logic [1:0]   elem_sel;
    logic         len_256;
    logic         res_valid;
    logic [255:0] res_vec;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    quad_shuffle i_quad_shuffle (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .src_vec  (src_vec),
        .dst_vec  (dst_vec),
        .shuf_imm (shuf_imm),
        .elem_sel (elem_sel),
        .len_256  (len_256),
        .res_valid(res_valid),
        .res_vec  (res_vec)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [255:0] act, input logic [255:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s w=%0d len256=%0d imm=%h act=%h exp=%h",
                     req, elem_sel, len_256, shuf_imm, act, exp);
        end
    endtask

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [255:0] model(input logic [255:0] s, input logic [255:0] d,
                                           input logic [7:0] imm, input int w, input bit wide);
        logic [255:0] r;
        r = '0;
        for (int ln = 0; ln < (wide ? 2 : 1); ln++) begin
            int lb;
            lb = ln * 128;
            if (w == 3) begin
                for (int h = 0; h < 2; h++) begin
                    int esel;
                    bit from_src;
                    esel     = imm[2*h] ? 1 : 0;
                    from_src = imm[2*h+1];
                    for (int b = 0; b < 64; b++)
                        r[lb + h*64 + b] = from_src ? s[lb + esel*64 + b] : d[lb + esel*64 + b];
                end
            end else begin
                int ew, ne;
                ew = 8 << w;
                ne = 128 / ew;
                for (int i = 0; i < ne; i++) begin
                    int p, srci;
                    p    = i % 4;
                    srci = (i / 4) * 4 + ((imm >> (2*p)) & 3);
                    for (int b = 0; b < ew; b++)
                        r[lb + i*ew + b] = s[lb + srci*ew + b];
                end
            end
        end
        return r;
    endfunction

    task automatic run_one(input int w, input bit wide, input int imm);
        logic [255:0] exp;
        @(negedge clk);
        src_vec  = rnd256();
        dst_vec  = rnd256();
        shuf_imm = 8'(imm);
        elem_sel = 2'(w);
        len_256  = wide;
        op_valid = 1'b1;
        exp = model(src_vec, dst_vec, shuf_imm, w, wide);
        @(negedge clk);
        op_valid = 1'b0;
        chk(res_valid === 1'b1, "R2 valid after op", {255'b0, res_valid}, 256'd1);
        if (w == 3) begin
            chk(res_vec[63:0] === exp[63:0], "R6 low dword lane0", res_vec, exp);
            chk(res_vec[127:64] === exp[127:64], "R7 high dword lane0", res_vec, exp);
        end else begin
            chk(res_vec[127:0] === exp[127:0], "R3 R4 lane0 shuffle", res_vec, exp);
        end
        if (wide)
            chk(res_vec[255:128] === exp[255:128], "R5 upper lane", res_vec, exp);
        else
            chk(res_vec[255:128] === 128'b0, "R8 upper cleared", res_vec, exp);
        @(negedge clk);
        chk(res_valid === 1'b0, "R2 single pulse", {255'b0, res_valid}, 256'd0);
        chk(res_vec === exp, "R2 hold when idle", res_vec, exp);
    endtask

    initial begin
        rst_n    = 1'b0;
        op_valid = 1'b0;
        src_vec  = '0;
        dst_vec  = '0;
        shuf_imm = '0;
        elem_sel = '0;
        len_256  = 1'b0;
        repeat (3) @(negedge clk);
        chk(res_valid === 1'b0, "R1 reset valid", {255'b0, res_valid}, 256'd0);
        chk(res_vec === '0, "R1 reset data", res_vec, 256'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_valid === 1'b0 && res_vec === '0, "R1 after release", res_vec, 256'd0);
        for (int w = 0; w < 4; w++)
            for (int wd = 0; wd < 2; wd++)
                for (int imm = 0; imm < 256; imm++)
                    run_one(w, wd[0], imm);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R2 watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule